// File: doc/BRIEF.md
# Wake Event Power Control

This block owns the main power enable of a system. It holds a 16-bit control word with one enable bit per wake source. The sources are ring indicate, sleep button, PCI power management event, power button, real-time clock alarm and SMBus slave address match. When a source is enabled and its latched status flag rises from 0 to 1, the active-low power enable output goes active. A status flag that stays high triggers only once. A flag whose enable is clear has no effect on the output.

The block also measures how long the power button and the sleep button are held. A tick input drives a prescaler, and the prescaler feeds a unit counter. A hold that lasts the full window forces soft-off and releases the power enable. Each button has its own override-disable bit that blocks this. When a soft-off and a wake land in the same cycle, soft-off wins. The status sources are debounced elsewhere, and the supply rails are sequenced by other logic.

Top module: `wake_pwr_ctl`

## Requirements
- R1: A cycle with `wr_en_i` high loads the control word, and `rd_data_o` shows the stored value from the next cycle on. Bits 15 (USB resume interrupt enable), 14 (ring enable), 13 (sleep override disable), 12 (sleep button enable), 11 (power override disable), 10 (PME enable), 9 (power button enable), 8 (RTC enable) and 3 (SMBus match enable) hold what was written.
- R2: After reset every control bit reads 0 and `pwr_en_no` is 1 (inactive).
- R3: Bits 7:4 and 2:0 always read 0, and writes to them are ignored.
- R4: Status input `wake_sts_i` bit k is paired with a control bit: bit 0 with 14, bit 1 with 12, bit 2 with 10, bit 3 with 9, bit 4 with 8, bit 5 with 3. When the paired bit is 1, a 0-to-1 change of the status bit drives `pwr_en_no` low at the same clock edge that samples the change.
- R5: A status bit whose paired control bit is 0 leaves `pwr_en_no` unchanged.
- R6: A status bit that stays high triggers at most once. Setting an enable while its status is already high does not trigger, and neither does a status still high after a soft-off.
- R7: With bit 11 at 0, holding `pwrbtn_held_i` for PRESCALE*HOLD_UNITS ticks (16 by default) drives `pwr_en_no` high at the edge that samples the last tick. Cycles without `tick_i` do not advance the count.
- R8: With bit 13 at 0, holding `slpbtn_held_i` for the same number of ticks forces the same soft-off.
- R9: With bit 11 (or bit 13) at 1, holding the matching button for any length of time does not change `pwr_en_no`.
- R10: Releasing a button before the window completes clears its count. The next hold needs the full window again.
- R11: When a soft-off and an enabled wake edge occur in the same cycle, `pwr_en_no` goes to 1.
- R12: One continuous hold forces soft-off only once. A wake edge during the same hold turns the power back on, and that state lasts until the button is released and held again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 16 | Control word read data |
| wake_sts_i | input | 6 | Latched wake status flags (ring, sleep, PME, power, RTC, SMBus) |
| tick_i | input | 1 | Timebase pulse for the hold timers |
| pwrbtn_held_i | input | 1 | Power button currently pressed |
| slpbtn_held_i | input | 1 | Sleep button currently pressed |
| pwr_en_no | output | 1 | Main power enable, active low |

## Verification
Errors in this block appear at the ports within a cycle or two. A stale edge-detect register shows up as a missed wake, or as a second wake, in the cycle after the status changes. A hold counter that is off by one moves the soft-off edge by one tick. A counter that is not cleared on release lets a second short press turn the power off. The bench sweeps all 64 enable combinations against each of the six sources, and it times each hold window to the exact tick.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;
    localparam int CTL_W  = 16;
    localparam int N_SRC  = 6;
    localparam int N_BTN  = 2;

    // control word bit positions
    localparam int B_USB_IE  = 15;
    localparam int B_RING_EN = 14;
    localparam int B_SB_OVD  = 13;
    localparam int B_SB_EN   = 12;
    localparam int B_PB_OVD  = 11;
    localparam int B_PME_EN  = 10;
    localparam int B_PB_EN   = 9;
    localparam int B_RTC_EN  = 8;
    localparam int B_SMB_EN  = 3;

    localparam logic [CTL_W-1:0] CTL_MASK = 16'hFF08;

    // status input indices
    localparam int S_RING = 0;
    localparam int S_SB   = 1;
    localparam int S_PME  = 2;
    localparam int S_PB   = 3;
    localparam int S_RTC  = 4;
    localparam int S_SMB  = 5;

    // hold timer indices
    localparam int T_PB = 0;
    localparam int T_SB = 1;

    typedef enum logic {
        PS_OFF = 1'b0,
        PS_ON  = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/wake_ctl_reg.sv
`timescale 1ns/1ps
module wake_ctl_reg
    import wake_pkg::*;
#(
    parameter logic [CTL_W-1:0] MASK = CTL_MASK
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output logic [CTL_W-1:0] ctl_o
);
    typedef struct packed {
        logic [CTL_W-1:0] word;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.word = wr_data_i & MASK;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.word;
endmodule

// File: rtl/wake_edge_gate.sv
`timescale 1ns/1ps
module wake_edge_gate #(
    parameter int NSRC = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] sts_i,
    input  logic [NSRC-1:0] en_i,
    output logic            trig_o
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NSRC-1:0] hit;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign hit[k] = sts_i[k] & ~st_q.prev[k] & en_i[k];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = sts_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = |hit;
endmodule

// File: rtl/wake_hold_timer.sv
`timescale 1ns/1ps
module wake_hold_timer #(
    parameter int PRESCALE   = 4,
    parameter int HOLD_UNITS = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic held_i,
    input  logic tick_i,
    output logic fire_o
);
    localparam int PRE_W  = (PRESCALE   > 1) ? $clog2(PRESCALE)   : 1;
    localparam int UNIT_W = (HOLD_UNITS > 1) ? $clog2(HOLD_UNITS) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRESCALE - 1);
    localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(HOLD_UNITS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [UNIT_W-1:0] units;
        logic              done;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!held_i) begin
            st_d = '0;
        end else if (tick_i && !st_q.done) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                if (st_q.units == UNIT_LAST) begin
                    st_d.units = '0;
                    st_d.done  = 1'b1;
                    fire       = 1'b1;
                end else begin
                    st_d.units = st_q.units + 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire;
endmodule

// File: rtl/wake_pwr_ctl.sv
`timescale 1ns/1ps
module wake_pwr_ctl
    import wake_pkg::*;
#(
    parameter int PRESCALE   = 4,
    parameter int HOLD_UNITS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output logic [CTL_W-1:0] rd_data_o,
    input  logic [N_SRC-1:0] wake_sts_i,
    input  logic             tick_i,
    input  logic             pwrbtn_held_i,
    input  logic             slpbtn_held_i,
    output logic             pwr_en_no
);
    typedef struct packed {
        pwr_state_e state;
    } top_st_t;

    logic [CTL_W-1:0] ctl;
    logic [N_SRC-1:0] src_en;
    logic             wake_trig;
    logic [N_BTN-1:0] btn_held;
    logic [N_BTN-1:0] btn_ovd;
    logic [N_BTN-1:0] btn_fire;
    logic             soft_off_req;
    top_st_t          st_d, st_q;

    wake_ctl_reg #(.MASK(CTL_MASK)) u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctl_o     (ctl)
    );

    always_comb begin
        src_en         = '0;
        src_en[S_RING] = ctl[B_RING_EN];
        src_en[S_SB]   = ctl[B_SB_EN];
        src_en[S_PME]  = ctl[B_PME_EN];
        src_en[S_PB]   = ctl[B_PB_EN];
        src_en[S_RTC]  = ctl[B_RTC_EN];
        src_en[S_SMB]  = ctl[B_SMB_EN];
    end

    wake_edge_gate #(.NSRC(N_SRC)) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sts_i  (wake_sts_i),
        .en_i   (src_en),
        .trig_o (wake_trig)
    );

    assign btn_held[T_PB] = pwrbtn_held_i;
    assign btn_held[T_SB] = slpbtn_held_i;
    assign btn_ovd[T_PB]  = ctl[B_PB_OVD];
    assign btn_ovd[T_SB]  = ctl[B_SB_OVD];

    for (genvar b = 0; b < N_BTN; b++) begin : g_btn
        wake_hold_timer #(
            .PRESCALE   (PRESCALE),
            .HOLD_UNITS (HOLD_UNITS)
        ) u_tmr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .held_i (btn_held[b]),
            .tick_i (tick_i),
            .fire_o (btn_fire[b])
        );
    end

    assign soft_off_req = |(btn_fire & ~btn_ovd);

    always_comb begin
        st_d = st_q;
        if (soft_off_req) begin
            st_d.state = PS_OFF;
        end else if (wake_trig) begin
            st_d.state = PS_ON;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.state <= PS_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_en_no = (st_q.state != PS_ON);
    assign rd_data_o = ctl;
endmodule

// File: rtl/wake_pwr_ctl_chk.sv
`timescale 1ns/1ps
module wake_pwr_ctl_chk
    import wake_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [CTL_W-1:0] wr_data_i,
    input logic [CTL_W-1:0] rd_data_o,
    input logic             pwr_en_no,
    input logic             wake_trig,
    input logic             soft_off_req,
    input logic [N_BTN-1:0] btn_fire
);
    p_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> rd_data_o == ($past(wr_data_i) & CTL_MASK));

    p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o & ~CTL_MASK) == '0);

    p_wake_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_trig && !soft_off_req) |=> !pwr_en_no);

    p_softoff_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_off_req |=> pwr_en_no);

    p_fall_needs_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pwr_en_no) |-> $past(wake_trig));

    p_rise_needs_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwr_en_no) |-> $past(soft_off_req));

    p_single_fire_pb_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        btn_fire[T_PB] |=> !btn_fire[T_PB]);

    p_single_fire_sb_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        btn_fire[T_SB] |=> !btn_fire[T_SB]);
endmodule

bind wake_pwr_ctl wake_pwr_ctl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .pwr_en_no    (pwr_en_no),
    .wake_trig    (wake_trig),
    .soft_off_req (soft_off_req),
    .btn_fire     (btn_fire)
);

// File: tb/wake_pwr_ctl_bench.sv
`timescale 1ns/1ps
module wake_pwr_ctl_bench;
    localparam int WIN = 16; // PRESCALE*HOLD_UNITS at defaults

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic [5:0]  wake_sts_i = '0;
    logic        tick_i = 1'b0;
    logic        pwrbtn_held_i = 1'b0;
    logic        slpbtn_held_i = 1'b0;
    logic        pwr_en_no;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk_i = ~clk_i;

    wake_pwr_ctl u_wake_pwr_ctl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_data_o     (rd_data_o),
        .wake_sts_i    (wake_sts_i),
        .tick_i        (tick_i),
        .pwrbtn_held_i (pwrbtn_held_i),
        .slpbtn_held_i (slpbtn_held_i),
        .pwr_en_no     (pwr_en_no)
    );

    function automatic int en_pos(input int s);
        case (s)
            0: return 14;
            1: return 12;
            2: return 10;
            3: return 9;
            4: return 8;
            default: return 3;
        endcase
    endfunction

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_ni = 1'b0; wake_sts_i = '0; tick_i = 0;
        pwrbtn_held_i = 0; slpbtn_held_i = 0; wr_en_i = 0;
        cyc(2);
        rst_ni = 1'b1;
        cyc(1);
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        cyc(1);
        wr_en_i = 1'b0;
    endtask

    task automatic wake_rtc();
        wake_sts_i[4] = 1'b1;
        cyc(1);
        wake_sts_i[4] = 1'b0;
        cyc(1);
    endtask

    // hold one button with a tick every cycle for n cycles
    task automatic hold_n(input bit sleep, input int n);
        tick_i = 1'b1;
        if (sleep) slpbtn_held_i = 1'b1; else pwrbtn_held_i = 1'b1;
        cyc(n);
        tick_i = 1'b0;
    endtask

    task automatic release_btns();
        pwrbtn_held_i = 0; slpbtn_held_i = 0; tick_i = 0;
        cyc(1);
    endtask

    initial begin
        cyc(200000 - 100);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2
        chk("R2 ctl reset", rd_data_o, 16'h0000);
        chk("R2 pwr reset", {15'd0, pwr_en_no}, 16'h0001);

        // R3 reserved bits
        wr(16'hFFFF);
        chk("R3 all ones", rd_data_o, 16'hFF08);
        wr(16'h00F7);
        chk("R3 reserved only", rd_data_o, 16'h0000);

        // R1 R4 R5 sweep of every enable combination against every source
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 6; s++) begin
                logic [15:0] w;
                w = '0;
                for (int k = 0; k < 6; k++) if (m[k]) w[en_pos(k)] = 1'b1;
                do_reset();
                wr(w | 16'h00F7);
                chk("R1 readback", rd_data_o, w);
                wake_sts_i[s] = 1'b1;
                cyc(1);
                if (m[s]) chk("R4 enabled wake", {15'd0, pwr_en_no}, 16'h0000);
                else      chk("R5 disabled wake", {15'd0, pwr_en_no}, 16'h0001);
                wake_sts_i[s] = 1'b0;
            end
        end

        // R6 enable after status already high
        do_reset();
        wake_sts_i[4] = 1'b1;
        cyc(2);
        wr(16'h0100);
        cyc(3);
        chk("R6 late enable", {15'd0, pwr_en_no}, 16'h0001);

        // R7 exact window, R6 status held through soft-off
        cyc(1);
        wake_sts_i[4] = 1'b0;
        wake_rtc();
        wake_sts_i[4] = 1'b1;
        cyc(1);
        chk("R7 on before hold", {15'd0, pwr_en_no}, 16'h0000);
        hold_n(0, WIN - 1);
        chk("R7 one tick short", {15'd0, pwr_en_no}, 16'h0000);
        hold_n(0, 1);
        chk("R7 window done", {15'd0, pwr_en_no}, 16'h0001);
        release_btns();
        cyc(3);
        chk("R6 level no retrigger", {15'd0, pwr_en_no}, 16'h0001);
        wake_sts_i[4] = 1'b0;
        cyc(1);

        // R7 ticks gate the count
        wake_rtc();
        pwrbtn_held_i = 1'b1;
        for (int i = 0; i < 2 * WIN; i++) begin
            tick_i = (i % 2 == 0);
            cyc(1);
            if (i == 2 * WIN - 3) chk("R7 gated short", {15'd0, pwr_en_no}, 16'h0000);
            if (i == 2 * WIN - 2) chk("R7 gated done", {15'd0, pwr_en_no}, 16'h0001);
        end
        release_btns();

        // R10 release clears count
        wake_rtc();
        hold_n(0, WIN - 1);
        release_btns();
        hold_n(0, WIN - 1);
        chk("R10 count cleared", {15'd0, pwr_en_no}, 16'h0000);
        // R11 soft-off and wake in the same cycle
        wake_sts_i[4] = 1'b1;
        hold_n(0, 1);
        chk("R11 soft-off wins", {15'd0, pwr_en_no}, 16'h0001);
        wake_sts_i[4] = 1'b0;
        // R12 wake during the same hold stays on
        pwrbtn_held_i = 1'b1;
        cyc(1);
        wake_sts_i[4] = 1'b1;
        cyc(1);
        wake_sts_i[4] = 1'b0;
        chk("R12 rewake", {15'd0, pwr_en_no}, 16'h0000);
        hold_n(0, 3 * WIN);
        chk("R12 single fire", {15'd0, pwr_en_no}, 16'h0000);
        release_btns();
        hold_n(0, WIN);
        chk("R12 new hold", {15'd0, pwr_en_no}, 16'h0001);
        release_btns();

        // R8 sleep button
        wake_rtc();
        hold_n(1, WIN - 1);
        chk("R8 sleep short", {15'd0, pwr_en_no}, 16'h0000);
        hold_n(1, 1);
        chk("R8 sleep done", {15'd0, pwr_en_no}, 16'h0001);
        release_btns();

        // R9 override disables
        wr(16'h0900);
        wake_rtc();
        hold_n(0, 3 * WIN);
        chk("R9 power ovd", {15'd0, pwr_en_no}, 16'h0000);
        release_btns();
        wr(16'h2100);
        hold_n(1, 3 * WIN);
        chk("R9 sleep ovd", {15'd0, pwr_en_no}, 16'h0000);
        hold_n(0, WIN);
        chk("R9 other button live", {15'd0, pwr_en_no}, 16'h0001);
        release_btns();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule